// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two N-bit signed two's complement operands and returns their exact 2N-bit signed product. The multiplier operand is recoded in overlapping three-bit windows into N/2 signed digits, each taking one of the values 0, +1, -1, +2 or -2. For every digit a partial product is formed from the multiplicand only by selecting it, doubling it with a one-place shift, and inverting it. Each partial product is sign-extended to 2N bits and placed two bit positions above the previous one. All of them are summed in one combinational tree. The sum is captured in an output register.

A caller presents both operands with `in_valid` high. The product and `out_valid` appear on the next rising clock edge. While `in_valid` is low the output register keeps its last value, so the product can be read at leisure. N must be even; the default is 8.

Top module: `booth_mul_r4`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `product` is all zeros, whatever the operand inputs are.
- R2: When `in_valid` is high at a rising edge, `out_valid` is 1 after that edge, and `product` equals the exact signed product of `mcand` and `mplier` as 2N-bit two's complement.
- R3: Digit g is taken from the window {mplier[2g+1], mplier[2g], mplier[2g-1]}, with 0 used below bit 0. Its value is -2*mplier[2g+1] + mplier[2g] + mplier[2g-1]. This gives exactly N/2 digits. No digit ever selects the single and the doubled multiplicand together, and no digit is negative when its magnitude is zero.
- R4: A digit of -2 applied to the most negative multiplicand gives the correct product. For example, at N=8, -128 times -2 gives +256.
- R5: When `in_valid` is low at a rising edge, `out_valid` is 0 after that edge and `product` keeps its previous value. The operand inputs have no effect in that cycle.
- R6: At N=4, 0111 (+7) times 1010 (-6) gives 11010110 (-42).
- R7: The extremes are exact. At N=8, -128 times -128 gives +16384, and 127 times 127 gives +16129.
- R8: A zero multiplier or a zero multiplicand gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier, the operand that is recoded |
| out_valid | output | 1 | Product register was loaded on the last edge |
| product | output | 2N | Signed product |

## Verification
At N=4 every pair of operands is tried. This covers every window pattern in every digit position, and it separates a wrong digit value from a wrong alignment or a missing carry-in of a negation. At N=8 a fixed table pins down the cases most likely to expose a bad sign extension or a lost +1. These are the doubled and negated most negative multiplicand, the two extremes, a product of minus one by minus one, and zero operands. Random pairs at N=8 then mix all digit values across the four positions. Directed steps check the reset value and that the register holds its value, whatever the inputs do, while `in_valid` is low.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;

  // One recoded digit: magnitude selects and sign.
  typedef struct packed {
    logic one;   // magnitude 1
    logic two;   // magnitude 2
    logic neg;   // digit is negative
  } bdigit_t;

  // Window {hi, mid, lo} -> digit value -2*hi + mid + lo
  function automatic bdigit_t recode_window(input logic [2:0] w);
    bdigit_t d;
    d.one = w[1] ^ w[0];
    d.two = (w == 3'b011) || (w == 3'b100);
    d.neg = w[2] & ~(w[1] & w[0]);
    return d;
  endfunction

  // Signed value of a digit, for reading and checking
  function automatic int digit_value(input bdigit_t d);
    int v;
    v = d.two ? 2 : (d.one ? 1 : 0);
    return d.neg ? -v : v;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_r4_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]           mplier,
  output bdigit_t [N/2-1:0]      digits
);
  localparam int NG = N / 2;

  logic [N:0] ext;
  assign ext = {mplier, 1'b0};

  for (genvar g = 0; g < NG; g++) begin : g_win
    assign digits[g] = recode_window(ext[2*g+2 : 2*g]);
  end

endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_r4_pkg::*;
#(
  parameter int N   = 8,
  parameter int IDX = 0
) (
  input  logic [N-1:0]   mcand,
  input  bdigit_t        digit,
  output logic [2*N-1:0] term,
  output logic [2*N-1:0] corr
);
  localparam int PW    = 2 * N;
  localparam int SHIFT = 2 * IDX;

  logic [N:0]    mag;
  logic [N:0]    flip;
  logic [PW-1:0] wide;

  always_comb begin
    if (digit.one)      mag = {mcand[N-1], mcand};
    else if (digit.two) mag = {mcand, 1'b0};
    else                mag = '0;
    flip = mag ^ {(N+1){digit.neg}};
    wide = {{(N-1){flip[N]}}, flip};
    term = wide << SHIFT;
    corr = {{(PW-1){1'b0}}, digit.neg} << SHIFT;
  end

endmodule

// File: rtl/booth_mul_r4.sv
module booth_mul_r4
  import booth_r4_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N-1:0]     mcand,
  input  logic [N-1:0]     mplier,
  output logic             out_valid,
  output logic [2*N-1:0]   product
);
  localparam int NG = N / 2;
  localparam int PW = 2 * N;

  bdigit_t [NG-1:0] digits;
  logic [PW-1:0]    terms [NG];
  logic [PW-1:0]    corrs [NG];
  logic [PW-1:0]    sum_w;

  // Named digit fields, brought out for the checker
  logic [NG-1:0] sel_one, sel_two, sel_neg;

  booth_recoder #(.N(N)) u_rec (
    .mplier (mplier),
    .digits (digits)
  );

  for (genvar g = 0; g < NG; g++) begin : g_pp
    assign sel_one[g] = digits[g].one;
    assign sel_two[g] = digits[g].two;
    assign sel_neg[g] = digits[g].neg;

    booth_ppgen #(.N(N), .IDX(g)) u_pp (
      .mcand (mcand),
      .digit (digits[g]),
      .term  (terms[g]),
      .corr  (corrs[g])
    );
  end

  always_comb begin
    sum_w = '0;
    for (int g = 0; g < NG; g++) begin
      sum_w = sum_w + terms[g] + corrs[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= sum_w;
    end
  end

endmodule

// File: rtl/booth_mul_r4_chk.sv
module booth_mul_r4_chk #(
  parameter int N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [N-1:0]     mcand,
  input logic [N-1:0]     mplier,
  input logic             out_valid,
  input logic [2*N-1:0]   product,
  input logic [N/2-1:0]   sel_one,
  input logic [N/2-1:0]   sel_two,
  input logic [N/2-1:0]   sel_neg
);
  logic signed [2*N-1:0] ref_p;
  assign ref_p = $signed({{N{mcand[N-1]}}, mcand}) * $signed({{N{mplier[N-1]}}, mplier});

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_product_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (product == $past(ref_p)));

  assert_digit_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_one & sel_two) == '0);

  assert_no_neg_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_neg & ~(sel_one | sel_two)) == '0);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(product)));

  assert_zero_operand_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mplier == '0 || mcand == '0)) |=> (product == '0));

endmodule

bind booth_mul_r4 booth_mul_r4_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mcand     (mcand),
  .mplier    (mplier),
  .out_valid (out_valid),
  .product   (product),
  .sel_one   (sel_one),
  .sel_two   (sel_two),
  .sel_neg   (sel_neg)
);

// File: tb/sim_booth_mul_r4.sv
module sim_booth_mul_r4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // N = 8 instance
  logic        v8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        ov8;
  logic [15:0] p8;

  // N = 4 instance
  logic        v4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        ov4;
  logic [7:0]  p4;

  booth_mul_r4 #(.N(8)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(v8),
    .mcand(a8), .mplier(b8), .out_valid(ov8), .product(p8));
  booth_mul_r4 #(.N(4)) u4 (.clk(clk), .rst_n(rst_n), .in_valid(v4),
    .mcand(a4), .mplier(b4), .out_valid(ov4), .product(p4));

  // {mcand, mplier, expected product} at N=8
  localparam int VEC [0:8][0:2] = '{
    '{   7,   -6,    -42},   // R2
    '{-128,   -2,    256},   // R4 doubled and negated most negative
    '{-128, -128,  16384},   // R7
    '{ 127,  127,  16129},   // R7
    '{-128,  127, -16256},   // R7
    '{  -1,   -1,      1},   // R2
    '{  85,  -86,  -7310},   // R2
    '{   0,  -77,      0},   // R8
    '{ -93,    0,      0}    // R8
  };

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run8(input int a, input int b, input int exp, input string tag);
    @(negedge clk);
    v8 = 1'b1; a8 = a[7:0]; b8 = b[7:0];
    @(negedge clk);
    v8 = 1'b0;
    check({tag, " valid"}, ov8, 1);
    check(tag, longint'($signed(p8)), exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with live inputs
    v8 = 1'b1; a8 = 8'h55; b8 = 8'h33;
    v4 = 1'b1; a4 = 4'h7; b4 = 4'h5;
    repeat (3) @(negedge clk);
    check("R1 out_valid", ov8, 0);
    check("R1 product", p8, 0);
    check("R1 product n4", p4, 0);
    v8 = 1'b0; v4 = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R6: example at N=4
    @(negedge clk);
    v4 = 1'b1; a4 = 4'b0111; b4 = 4'b1010;
    @(negedge clk);
    v4 = 1'b0;
    check("R6 product", p4, 8'b11010110);

    // Table walk (R2, R4, R7, R8)
    for (int i = 0; i <= 8; i++) begin
      run8(VEC[i][0], VEC[i][1], VEC[i][2], "R2 table");
    end

    // R5: idle cycle with changing inputs keeps the product
    run8(-77, 55, -4235, "R2 before hold");
    @(negedge clk);
    a8 = 8'h12; b8 = 8'h9c;
    @(negedge clk);
    check("R5 out_valid", ov8, 0);
    check("R5 product", longint'($signed(p8)), -4235);

    // R3: exhaustive at N=4, every window in every position
    for (int a = -8; a < 8; a++) begin
      for (int b = -8; b < 8; b++) begin
        @(negedge clk);
        v4 = 1'b1; a4 = a[3:0]; b4 = b[3:0];
        @(negedge clk);
        v4 = 1'b0;
        check("R3 exhaustive n4", longint'($signed(p4)), a * b);
      end
    end

    // R2: random at N=8
    for (int k = 0; k < 300; k++) begin
      int ra, rb;
      ra = int'($signed(8'($urandom)));
      rb = int'($signed(8'($urandom)));
      run8(ra, rb, ra * rb, "R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule